// File: doc/BRIEF.md
# Memory dependency group tracker

This block keeps a small table of memory groups for an out-of-order scheduler. A group collects memory operations that are independent of each other and share the same dependencies on older memory operations. Each table entry counts its predecessor groups (all of them, those currently issuing, and those finished) and its own members (all of them, those issued and in flight, and those executed). It also stores two successor bit-vectors: one for ordering edges and one for data edges.

One command is applied per clock: create a group, add a member, add an edge, report a member issued, or report a member executed. An independent tick input runs at the same time. An ordering edge releases its successor as soon as the source group has every remaining member in flight. A data edge first marks the successor as having an issuing predecessor and only releases it once every member of the source has executed. A query port returns the three-way dependency state of any group, together with its critical-predecessor countdown. Bad commands set a sticky error flag and change nothing else.

Top module: `mdg_tracker`

## Requirements
- R1: After reset no group exists and `new_id_o` is 1. `new_id_o` always shows the identifier that the next create will take: the lowest free slot index plus 1, or 0 when all 16 slots are in use. A create takes that identifier. Identifier 0 is never a valid group.
- R2: `state_o` reports the queried group as 0 (no such group), 1 waiting (total predecessors exceed issuing plus finished), 2 pending (at least one issuing, and issuing plus finished equals the total) or 3 ready (finished equals total). A new group is ready.
- R3: An ordering edge (`edge_data_i`=0) adds one predecessor to its destination. The clock edge at which the source reaches the state where every unexecuted member is issued and at least one is in flight counts that predecessor as finished.
- R4: A data edge (`edge_data_i`=1) adds one predecessor. It counts as issuing at the source's issuing transition and moves to finished at the clock edge where the source's last member executes.
- R5: An ordering edge added from a group that is already issuing has no effect. A data edge added from an issuing group counts as an issuing predecessor at once.
- R6: Each group holds a critical countdown. An issuing event carried over a data edge raises it to the source's largest member latency (`lat_i` of its issued members) if that is larger. On a tick it falls by 1 if the group is waiting and the value is nonzero. When both happen in one cycle, the decrement is applied first and the maximum second.
- R7: A group is freed at the clock edge where its last member executes. Its identifier then reads as state 0 and can be reused by the next create.
- R8: `err_o` is set by any of these, and the offending command has no effect: a create while the table is full; an unknown or freed identifier; an edge from a group to itself; adding a member to a group that has successors; issuing in a group that is not ready or has no unissued member; executing in a group that is not ready or has no member in flight.
- R9: `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: 0 none, 1 create, 2 add member, 3 add edge, 4 member issued, 5 member executed |
| id_i | input | 5 | Target group, or source group of an edge |
| dst_i | input | 5 | Destination group of an edge |
| edge_data_i | input | 1 | Edge kind: 1 data, 0 ordering |
| lat_i | input | 8 | Latency of the issued member |
| tick_i | input | 1 | Cycle tick for the critical countdown |
| qry_id_i | input | 5 | Group to query |
| new_id_o | output | 5 | Identifier the next create will take, 0 if full |
| state_o | output | 2 | State of the queried group |
| crit_o | output | 8 | Critical countdown of the queried group |
| err_o | output | 1 | Sticky illegal-command flag |

## Verification
The tick and a member-issued command can act on the same group in one cycle. The countdown decrement and the data-edge maximum then compete for the same register. The bench lets a waiting group's countdown run, and in the cycle that a data predecessor starts issuing with a smaller latency it also asserts tick. It expects the decremented value to survive the maximum, and the group to read pending. The executed command has the same kind of overlap: it frees its own slot and releases data successors in one edge, and the bench follows it with a create that must reuse the lowest freed identifier.

// File: rtl/mdg_pkg.sv
package mdg_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_CREATE   = 3'd1,
    CMD_ADD_MEM  = 3'd2,
    CMD_ADD_EDGE = 3'd3,
    CMD_ISSUE    = 3'd4,
    CMD_EXEC     = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ST_NONE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PEND  = 2'd2,
    ST_READY = 2'd3
  } grp_state_e;
endpackage

// File: rtl/mdg_alloc.sv
module mdg_alloc #(
  parameter int unsigned N    = 16,
  parameter int unsigned ID_W = $clog2(N + 1)
) (
  input  logic [N-1:0]    valid_i,
  output logic [ID_W-1:0] new_id_o
);
  // lowest free slot wins
  always_comb begin
    new_id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) new_id_o = ID_W'(i + 1);
    end
  end
endmodule

// File: rtl/mdg_dec.sv
module mdg_dec import mdg_pkg::*; #(
  parameter int unsigned N     = 16,
  parameter int unsigned ID_W  = $clog2(N + 1),
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [ID_W-1:0]  dst_i,
  input  logic             data_i,
  input  logic [ID_W-1:0]  new_id_i,
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     can_iss_i,
  input  logic [N-1:0]     can_exe_i,
  input  logic [N-1:0]     has_succ_i,
  input  logic [N-1:0]     mem_full_i,
  input  logic [N-1:0]     pred_full_i,
  input  logic [N-1:0]     issuing_i,
  output logic [N-1:0]     create_o,
  output logic [N-1:0]     add_mem_o,
  output logic [N-1:0]     add_pred_o,
  output logic [N-1:0]     iss_o,
  output logic [N-1:0]     exe_o,
  output logic [N-1:0]     edge_iss_o,
  output logic [N-1:0]     src_oh_o,
  output logic             set_ord_o,
  output logic             set_dat_o,
  output logic [IDX_W-1:0] dst_idx_o,
  output logic             err_o
);
  function automatic logic [N-1:0] to_oh(input logic [ID_W-1:0] v);
    to_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (v == ID_W'(i + 1)) to_oh[i] = 1'b1;
    end
  endfunction

  logic [N-1:0] src_oh, dst_oh, new_oh;
  logic         src_ok, dst_ok, src_iss, bad;
  logic         err_q;

  assign src_oh    = to_oh(id_i);
  assign dst_oh    = to_oh(dst_i);
  assign new_oh    = to_oh(new_id_i);
  assign src_ok    = |(src_oh & valid_i);
  assign dst_ok    = |(dst_oh & valid_i);
  assign src_iss   = |(src_oh & issuing_i);
  assign src_oh_o  = src_oh;
  assign dst_idx_o = IDX_W'(dst_i - ID_W'(1));

  always_comb begin
    create_o   = '0;
    add_mem_o  = '0;
    add_pred_o = '0;
    iss_o      = '0;
    exe_o      = '0;
    edge_iss_o = '0;
    set_ord_o  = 1'b0;
    set_dat_o  = 1'b0;
    bad        = 1'b0;
    case (cmd_i)
      CMD_NOP: ;
      CMD_CREATE: begin
        if (new_id_i == '0) bad = 1'b1;
        else create_o = new_oh;
      end
      CMD_ADD_MEM: begin
        if (!src_ok || |(src_oh & (has_succ_i | mem_full_i))) bad = 1'b1;
        else add_mem_o = src_oh;
      end
      CMD_ADD_EDGE: begin
        if (!src_ok || !dst_ok || src_oh == dst_oh || |(dst_oh & pred_full_i)) begin
          bad = 1'b1;
        end else if (data_i) begin
          add_pred_o = dst_oh;
          set_dat_o  = 1'b1;
          if (src_iss) edge_iss_o = dst_oh;
        end else if (!src_iss) begin
          add_pred_o = dst_oh;
          set_ord_o  = 1'b1;
        end
      end
      CMD_ISSUE: begin
        if (|(src_oh & can_iss_i)) iss_o = src_oh;
        else bad = 1'b1;
      end
      CMD_EXEC: begin
        if (|(src_oh & can_exe_i)) exe_o = src_oh;
        else bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | bad;
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R9
  AST_ERR_ON_FULL_CREATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CREATE && valid_i == '1) |=> err_q); // R8
endmodule

// File: rtl/mdg_slot.sv
module mdg_slot import mdg_pkg::*; #(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned CYC_W = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             create_i,
  input  logic             add_mem_i,
  input  logic             add_pred_i,
  input  logic             iss_i,
  input  logic             exe_i,
  input  logic [CYC_W-1:0] lat_i,
  input  logic             ev_iss_i,
  input  logic             ev_fin_i,
  input  logic             ev_i2f_i,
  input  logic [CYC_W-1:0] crit_val_i,
  input  logic             tick_i,
  input  logic             set_ord_i,
  input  logic             set_dat_i,
  input  logic [IDX_W-1:0] succ_idx_i,
  input  logic [N-1:0]     clr_col_i,
  output logic             valid_o,
  output logic             issuing_o,
  output logic             can_iss_o,
  output logic             can_exe_o,
  output logic             has_succ_o,
  output logic             mem_full_o,
  output logic             pred_full_o,
  output logic             start_o,
  output logic             done_o,
  output logic [CYC_W-1:0] crit_mem_o,
  output logic [N-1:0]     ord_o,
  output logic [N-1:0]     dat_o,
  output logic [1:0]       state_o,
  output logic [CYC_W-1:0] crit_o
);
  localparam logic [CNT_W-1:0] C1 = CNT_W'(1);

  logic             valid_q;
  logic [CNT_W-1:0] n_pred_q, n_piss_q, n_pfin_q, n_mem_q, n_iss_q, n_exd_q;
  logic [CYC_W-1:0] crit_q, crit_mem_q, crit_d;
  logic [N-1:0]     ord_q, dat_q, ord_d, dat_d;
  logic [CNT_W:0]   pred_sum;
  logic [CNT_W-1:0] remaining;
  logic             waiting, pending, ready;

  assign pred_sum  = {1'b0, n_piss_q} + {1'b0, n_pfin_q};
  assign waiting   = {1'b0, n_pred_q} > pred_sum;
  assign pending   = (n_piss_q != '0) && (pred_sum == {1'b0, n_pred_q});
  assign ready     = n_pfin_q == n_pred_q;
  assign remaining = n_mem_q - n_exd_q;

  assign valid_o     = valid_q;
  assign issuing_o   = valid_q && (n_iss_q != '0) && (n_iss_q == remaining);
  assign can_iss_o   = valid_q && ready && (n_iss_q < remaining);
  assign can_exe_o   = valid_q && ready && (n_iss_q != '0);
  assign has_succ_o  = |{ord_q, dat_q};
  assign mem_full_o  = &n_mem_q;
  assign pred_full_o = &n_pred_q;
  assign start_o     = iss_i && ((n_iss_q + C1) == remaining);
  assign done_o      = exe_i && ((n_exd_q + C1) == n_mem_q);
  assign crit_mem_o  = (iss_i && lat_i > crit_mem_q) ? lat_i : crit_mem_q;
  assign ord_o       = ord_q;
  assign dat_o       = dat_q;
  assign crit_o      = valid_q ? crit_q : '0;

  always_comb begin
    if (!valid_q)     state_o = ST_NONE;
    else if (ready)   state_o = ST_READY;
    else if (pending) state_o = ST_PEND;
    else              state_o = ST_WAIT;
  end

  // tick decrement first, data-edge maximum second
  always_comb begin
    crit_d = crit_q;
    if (tick_i && waiting && crit_q != '0) crit_d = crit_q - CYC_W'(1);
    if (ev_iss_i && crit_val_i > crit_d) crit_d = crit_val_i;
  end

  always_comb begin
    ord_d = ord_q;
    dat_d = dat_q;
    if (set_ord_i) ord_d[succ_idx_i] = 1'b1;
    if (set_dat_i) dat_d[succ_idx_i] = 1'b1;
    ord_d = ord_d & ~clr_col_i;
    dat_d = dat_d & ~clr_col_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      n_pred_q   <= '0;
      n_piss_q   <= '0;
      n_pfin_q   <= '0;
      n_mem_q    <= '0;
      n_iss_q    <= '0;
      n_exd_q    <= '0;
      crit_q     <= '0;
      crit_mem_q <= '0;
      ord_q      <= '0;
      dat_q      <= '0;
    end else if (create_i) begin
      valid_q    <= 1'b1;
      n_pred_q   <= '0;
      n_piss_q   <= '0;
      n_pfin_q   <= '0;
      n_mem_q    <= '0;
      n_iss_q    <= '0;
      n_exd_q    <= '0;
      crit_q     <= '0;
      crit_mem_q <= '0;
      ord_q      <= '0;
      dat_q      <= '0;
    end else begin
      if (done_o) valid_q <= 1'b0;
      if (add_mem_i) n_mem_q <= n_mem_q + C1;
      if (add_pred_i) n_pred_q <= n_pred_q + C1;
      if (ev_iss_i)      n_piss_q <= n_piss_q + C1;
      else if (ev_i2f_i) n_piss_q <= n_piss_q - C1;
      if (ev_fin_i || ev_i2f_i) n_pfin_q <= n_pfin_q + C1;
      if (iss_i)      n_iss_q <= n_iss_q + C1;
      else if (exe_i) n_iss_q <= n_iss_q - C1;
      if (exe_i) n_exd_q <= n_exd_q + C1;
      if (done_o)     crit_mem_q <= '0;
      else if (iss_i) crit_mem_q <= crit_mem_o;
      crit_q <= crit_d;
      ord_q  <= ord_d;
      dat_q  <= dat_d;
    end
  end

  AST_PRED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (pred_sum <= {1'b0, n_pred_q})); // R2
  AST_MEMBER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (({1'b0, n_iss_q} + {1'b0, n_exd_q}) <= {1'b0, n_mem_q})); // R8
  AST_FREE_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !valid_q); // R7
  AST_CRIT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !create_i && tick_i && waiting && crit_q != '0 && !ev_iss_i)
      |=> (crit_q == $past(crit_q) - CYC_W'(1))); // R6
endmodule

// File: rtl/mdg_tracker.sv
module mdg_tracker import mdg_pkg::*; #(
  parameter int unsigned N_GRP = 16,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned CYC_W = 8,
  parameter int unsigned ID_W  = $clog2(N_GRP + 1),
  parameter int unsigned IDX_W = $clog2(N_GRP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [ID_W-1:0]  dst_i,
  input  logic             edge_data_i,
  input  logic [CYC_W-1:0] lat_i,
  input  logic             tick_i,
  input  logic [ID_W-1:0]  qry_id_i,
  output logic [ID_W-1:0]  new_id_o,
  output logic [1:0]       state_o,
  output logic [CYC_W-1:0] crit_o,
  output logic             err_o
);
  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic [N_GRP-1:0] valid_v, issuing_v, can_iss_v, can_exe_v, has_succ_v;
  logic [N_GRP-1:0] mem_full_v, pred_full_v, start_v, done_v;
  logic [N_GRP-1:0] create_v, add_mem_v, add_pred_v, iss_v, exe_v, edge_iss_v, src_oh;
  logic [N_GRP-1:0] ev_iss, ev_fin, ev_i2f;
  logic [N_GRP-1:0] ord_m [N_GRP];
  logic [N_GRP-1:0] dat_m [N_GRP];
  logic [CYC_W-1:0] crit_mem_m [N_GRP];
  logic [CYC_W-1:0] crit_m [N_GRP];
  logic [1:0]       st_m [N_GRP];
  logic [CYC_W-1:0] crit_val;
  logic             set_ord, set_dat;
  logic [IDX_W-1:0] dst_idx, qslot, nslot;
  logic [ID_W-1:0]  new_id;
  logic             q_in_rng;

  mdg_alloc #(.N(N_GRP), .ID_W(ID_W)) u_alloc (
    .valid_i (valid_v),
    .new_id_o(new_id)
  );

  mdg_dec #(.N(N_GRP), .ID_W(ID_W), .IDX_W(IDX_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .id_i       (id_i),
    .dst_i      (dst_i),
    .data_i     (edge_data_i),
    .new_id_i   (new_id),
    .valid_i    (valid_v),
    .can_iss_i  (can_iss_v),
    .can_exe_i  (can_exe_v),
    .has_succ_i (has_succ_v),
    .mem_full_i (mem_full_v),
    .pred_full_i(pred_full_v),
    .issuing_i  (issuing_v),
    .create_o   (create_v),
    .add_mem_o  (add_mem_v),
    .add_pred_o (add_pred_v),
    .iss_o      (iss_v),
    .exe_o      (exe_v),
    .edge_iss_o (edge_iss_v),
    .src_oh_o   (src_oh),
    .set_ord_o  (set_ord),
    .set_dat_o  (set_dat),
    .dst_idx_o  (dst_idx),
    .err_o      (err_o)
  );

  // fan source transitions out along successor vectors
  always_comb begin
    ev_fin   = '0;
    ev_iss   = edge_iss_v;
    ev_i2f   = '0;
    crit_val = '0;
    for (int i = 0; i < N_GRP; i++) begin
      if (src_oh[i]) crit_val = crit_val | crit_mem_m[i];
      for (int j = 0; j < N_GRP; j++) begin
        if (start_v[i] && ord_m[i][j]) ev_fin[j] = 1'b1;
        if (start_v[i] && dat_m[i][j]) ev_iss[j] = 1'b1;
        if (done_v[i]  && dat_m[i][j]) ev_i2f[j] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_slot
    mdg_slot #(.N(N_GRP), .CNT_W(CNT_W), .CYC_W(CYC_W), .IDX_W(IDX_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .create_i   (create_v[g]),
      .add_mem_i  (add_mem_v[g]),
      .add_pred_i (add_pred_v[g]),
      .iss_i      (iss_v[g]),
      .exe_i      (exe_v[g]),
      .lat_i      (lat_i),
      .ev_iss_i   (ev_iss[g]),
      .ev_fin_i   (ev_fin[g]),
      .ev_i2f_i   (ev_i2f[g]),
      .crit_val_i (crit_val),
      .tick_i     (tick_i),
      .set_ord_i  (set_ord && src_oh[g]),
      .set_dat_i  (set_dat && src_oh[g]),
      .succ_idx_i (dst_idx),
      .clr_col_i  (done_v),
      .valid_o    (valid_v[g]),
      .issuing_o  (issuing_v[g]),
      .can_iss_o  (can_iss_v[g]),
      .can_exe_o  (can_exe_v[g]),
      .has_succ_o (has_succ_v[g]),
      .mem_full_o (mem_full_v[g]),
      .pred_full_o(pred_full_v[g]),
      .start_o    (start_v[g]),
      .done_o     (done_v[g]),
      .crit_mem_o (crit_mem_m[g]),
      .ord_o      (ord_m[g]),
      .dat_o      (dat_m[g]),
      .state_o    (st_m[g]),
      .crit_o     (crit_m[g])
    );
  end

  assign q_in_rng = (qry_id_i != '0) && (qry_id_i <= ID_W'(N_GRP));
  assign qslot    = IDX_W'(qry_id_i - ID_W'(1));
  assign nslot    = IDX_W'(new_id - ID_W'(1));
  assign state_o  = q_in_rng ? st_m[qslot] : 2'd0;
  assign crit_o   = q_in_rng ? crit_m[qslot] : '0;
  assign new_id_o = new_id;

  AST_NEW_ID_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_id != '0) |-> !valid_v[nslot]); // R1
  AST_CREATE_TAKES_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_CREATE && new_id != '0) |=> valid_v[$past(nslot)]); // R1
  AST_ORDER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_v | done_v)); // R3
endmodule

// File: tb/sim_mdg_tracker.sv
`timescale 1ns/1ps
module sim_mdg_tracker;
  typedef struct packed {
    logic [2:0] cmd;
    logic [4:0] id;
    logic [4:0] dst;
    logic       dat;
    logic [7:0] lat;
    logic       tick;
    logic [4:0] qid;
    logic [1:0] st;
    logic [7:0] crit;
  } vec_t;

  localparam int NV = 20;
  // cmd, id, dst, data, lat, tick, query, exp state, exp crit
  localparam vec_t VEC [NV] = '{
    '{3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0, 5'd1, 2'd3, 8'd0},
    '{3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0, 5'd2, 2'd3, 8'd0},
    '{3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0, 5'd3, 2'd3, 8'd0},
    '{3'd2, 5'd1, 5'd0, 1'b0, 8'd0, 1'b0, 5'd1, 2'd3, 8'd0},
    '{3'd2, 5'd1, 5'd0, 1'b0, 8'd0, 1'b0, 5'd1, 2'd3, 8'd0},
    '{3'd2, 5'd2, 5'd0, 1'b0, 8'd0, 1'b0, 5'd2, 2'd3, 8'd0},
    '{3'd2, 5'd3, 5'd0, 1'b0, 8'd0, 1'b0, 5'd3, 2'd3, 8'd0},
    '{3'd3, 5'd1, 5'd2, 1'b0, 8'd0, 1'b0, 5'd2, 2'd1, 8'd0},
    '{3'd3, 5'd1, 5'd3, 1'b1, 8'd0, 1'b0, 5'd3, 2'd1, 8'd0},
    '{3'd3, 5'd2, 5'd3, 1'b1, 8'd0, 1'b0, 5'd3, 2'd1, 8'd0},
    '{3'd4, 5'd1, 5'd0, 1'b0, 8'd4, 1'b0, 5'd2, 2'd1, 8'd0},
    '{3'd4, 5'd1, 5'd0, 1'b0, 8'd9, 1'b0, 5'd3, 2'd1, 8'd9},
    '{3'd0, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0, 5'd2, 2'd3, 8'd0},
    '{3'd0, 5'd0, 5'd0, 1'b0, 8'd0, 1'b1, 5'd3, 2'd1, 8'd8},
    '{3'd4, 5'd2, 5'd0, 1'b0, 8'd3, 1'b1, 5'd3, 2'd2, 8'd7},
    '{3'd0, 5'd0, 5'd0, 1'b0, 8'd0, 1'b1, 5'd3, 2'd2, 8'd7},
    '{3'd5, 5'd2, 5'd0, 1'b0, 8'd0, 1'b0, 5'd2, 2'd0, 8'd0},
    '{3'd5, 5'd1, 5'd0, 1'b0, 8'd0, 1'b0, 5'd3, 2'd2, 8'd7},
    '{3'd5, 5'd1, 5'd0, 1'b0, 8'd0, 1'b0, 5'd3, 2'd3, 8'd7},
    '{3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0, 5'd1, 2'd3, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = '0;
  logic [4:0] id = '0, dst = '0, qry = '0;
  logic       dat = 1'b0, tick = 1'b0;
  logic [7:0] lat = '0;
  logic [4:0] new_id;
  logic [1:0] st;
  logic [7:0] crit;
  logic       err;
  int         checks = 0, errors = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  mdg_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .id_i(id), .dst_i(dst),
    .edge_data_i(dat), .lat_i(lat), .tick_i(tick), .qry_id_i(qry),
    .new_id_o(new_id), .state_o(st), .crit_o(crit), .err_o(err)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [4:0] a, input logic [4:0] b,
                      input logic d, input logic [7:0] l, input logic t);
    @(negedge clk);
    cmd = c; id = a; dst = b; dat = d; lat = l; tick = t;
    @(posedge clk);
    #1;
    cmd = '0; tick = 1'b0;
  endtask

  task automatic look(input logic [4:0] q);
    qry = q;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic string tag_of(int k);
    if (k < 7)       return "R2";
    else if (k == 7) return "R3";
    else if (k < 10) return "R4";
    else if (k < 13) return "R3";
    else if (k < 16) return "R6";
    else if (k == 16) return "R7";
    else if (k < 19) return "R4";
    else             return "R1";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    look(5'd1);
    chk("R1 reset new id", int'(new_id), 1);
    chk("R9 reset err", int'(err), 0);
    chk("R1 reset state", int'(st), 0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].cmd, VEC[k].id, VEC[k].dst, VEC[k].dat, VEC[k].lat, VEC[k].tick);
      look(VEC[k].qid);
      chk({tag_of(k), " state"}, int'(st), int'(VEC[k].st));
      chk({tag_of(k), " crit"}, int'(crit), int'(VEC[k].crit));
    end

    // groups 1 and 3 live: next id is 2
    chk("R1 lowest free", int'(new_id), 2);
    step(3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    step(3'd2, 5'd2, 5'd0, 1'b0, 8'd0, 1'b0);
    step(3'd4, 5'd2, 5'd0, 1'b0, 8'd5, 1'b0);
    step(3'd3, 5'd2, 5'd1, 1'b0, 8'd0, 1'b0);
    look(5'd1);
    chk("R5 order edge ignored", int'(st), 3);
    step(3'd3, 5'd2, 5'd3, 1'b1, 8'd0, 1'b0);
    look(5'd3);
    chk("R5 data edge issuing", int'(st), 2);
    chk("R5 data edge crit", int'(crit), 7);
    chk("R8 no error yet", int'(err), 0);
    step(3'd4, 5'd3, 5'd0, 1'b0, 8'd1, 1'b0);
    look(5'd3);
    chk("R8 issue not ready err", int'(err), 1);
    chk("R8 issue not ready no effect", int'(st), 2);
    repeat (3) step(3'd0, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    chk("R9 err sticky", int'(err), 1);

    do_reset();
    look(5'd1);
    chk("R9 err cleared", int'(err), 0);
    chk("R7 state after reset", int'(st), 0);
    step(3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    step(3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    step(3'd2, 5'd1, 5'd0, 1'b0, 8'd0, 1'b0);
    step(3'd3, 5'd1, 5'd2, 1'b0, 8'd0, 1'b0);
    step(3'd2, 5'd1, 5'd0, 1'b0, 8'd0, 1'b0);
    chk("R8 member after successor err", int'(err), 1);
    step(3'd4, 5'd1, 5'd0, 1'b0, 8'd2, 1'b0);
    look(5'd2);
    chk("R8 member not added", int'(st), 3);

    do_reset();
    step(3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    step(3'd2, 5'd1, 5'd0, 1'b0, 8'd0, 1'b0);
    step(3'd5, 5'd1, 5'd0, 1'b0, 8'd0, 1'b0);
    chk("R8 exec none in flight", int'(err), 1);

    do_reset();
    for (int k = 0; k < 16; k++) step(3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    chk("R1 full new id", int'(new_id), 0);
    chk("R8 no err before full create", int'(err), 0);
    step(3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    chk("R8 create when full", int'(err), 1);

    do_reset();
    step(3'd1, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    step(3'd3, 5'd1, 5'd1, 1'b1, 8'd0, 1'b0);
    look(5'd1);
    chk("R8 self edge err", int'(err), 1);
    chk("R8 self edge no effect", int'(st), 3);

    do_reset();
    step(3'd2, 5'd0, 5'd0, 1'b0, 8'd0, 1'b0);
    chk("R8 id zero err", int'(err), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule